// File: doc/BRIEF.md
# 3D Element Index Remapping Generator

This block turns a vector loop's linear element count into a sequence of remapped element indices. A 32-bit shape word, sampled on a start pulse, treats the element range as a three-dimensional array of up to 63 by 63 by 63 elements. The block walks the array in a programmable nesting order, with an optional reversal on each axis. At each coordinate it forms the flat index x + y*xdim + z*xdim*ydim. It can also wrap that index by a modulus before it leaves the block.

One index is offered per cycle under a valid/ready handshake. A last flag marks the final index, and the block then goes idle until the next start pulse. If the shape word is all zeros, no remapping is done: the block emits a plain counter 0, 1, 2, ... whose length comes from a separate length input. Typical uses are matrix transposes and strided reuse of a short operand against a longer one, with no software index arithmetic.

Top module: `idx_remap_gen`

## Requirements
- R1: After reset is released, valid_o and last_o are low and idx_o is zero.
- R2: The first index of a sequence is on idx_o with valid_o high in the cycle after start_i is sampled. The output moves to the next index on every clock edge where valid_o and ready_i are both high. While ready_i is low, valid_o, idx_o and last_o hold.
- R3: Shape word fields: x size in bits 5..0, y size in bits 11..6, z size in bits 17..12, order code in bits 20..18, reversal bits in 23..21, modulus in 29..24. Each index equals px + py*xs + pz*xs*ys, where p are the per-axis positions and s the axis sizes.
- R4: An axis size field of zero acts as size 1.
- R5: Order codes, listed from innermost to outermost axis: 0 = x,y,z; 1 = x,z,y; 2 = y,x,z; 3 = y,z,x; 4 = z,x,y; 5 = z,y,x. Codes 6 and 7 behave as code 0. The innermost axis steps on every index. When an axis passes its last value it returns to its start and the next axis in the order steps.
- R6: Reversal bit 0 runs x from size-1 down to 0 instead of from 0 up. Bits 1 and 2 do the same for y and z.
- R7: A nonzero modulus m makes every index equal to the unwrapped index mod m, so every index is below m. A modulus of zero leaves the index unwrapped.
- R8: A shaped sequence has exactly xs*ys*zs indices. last_o is high with the final index only. After the final handshake valid_o goes low.
- R9: An all-zero shape word gives idx_o = 0, 1, ..., L-1, where L is vl_i sampled at start, and a vl_i of zero gives L = 1.
- R10: A start pulse while a sequence is running abandons it. The new sequence's first index is due one cycle later, whatever the state of ready_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; samples cfg_i and vl_i |
| cfg_i | input | 32 | Shape word |
| vl_i | input | 18 | Sequence length used when the shape word is zero |
| ready_i | input | 1 | Consumer accepts the current index |
| valid_o | output | 1 | idx_o holds a sequence element |
| idx_o | output | 18 | Remapped element index |
| last_o | output | 1 | Current index is the final one |

## Verification
Every result is registered, so each one is due exactly one clock edge after the edge that samples its cause. The first index follows the edge that sees start_i. Each later index follows the edge that sees valid_o and ready_i together, and the idle state follows the edge that takes the last index. The bench drives all inputs on falling edges and reads the outputs on the next falling edge, half a cycle after the edge that was due to update them. It compares each index with a model that gets the coordinates of element n by mixed-radix division instead of stepping a counter.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int unsigned DIM_W  = 6;
  localparam int unsigned NAX    = 3;
  localparam int unsigned PERM_W = 3;
  localparam int unsigned CFG_W  = 32;
  localparam int unsigned AX_W   = 2;
  localparam int unsigned IDX_W  = NAX * DIM_W;

  localparam int unsigned X_LSB = 0;
  localparam int unsigned Y_LSB = DIM_W;
  localparam int unsigned Z_LSB = 2 * DIM_W;
  localparam int unsigned P_LSB = 3 * DIM_W;
  localparam int unsigned I_LSB = P_LSB + PERM_W;
  localparam int unsigned M_LSB = I_LSB + NAX;

  typedef logic [AX_W-1:0] axis_t;
  localparam axis_t AX_X = 2'd0;
  localparam axis_t AX_Y = 2'd1;
  localparam axis_t AX_Z = 2'd2;

  typedef struct packed {
    logic                          bypass;
    logic [DIM_W-1:0]              modv;
    logic [NAX-1:0]                inv;
    axis_t [NAX-1:0]               order;  // [0] innermost
    logic [NAX-1:0][DIM_W-1:0]     lim;
  } shape_t;

  function automatic logic [DIM_W-1:0] eff_size(logic [DIM_W-1:0] f);
    return (f == '0) ? DIM_W'(1) : f;
  endfunction

  function automatic shape_t decode_shape(logic [CFG_W-1:0] w);
    shape_t s;
    s.bypass = (w == '0);
    s.modv   = w[M_LSB +: DIM_W];
    s.inv    = w[I_LSB +: NAX];
    s.lim[0] = eff_size(w[X_LSB +: DIM_W]);
    s.lim[1] = eff_size(w[Y_LSB +: DIM_W]);
    s.lim[2] = eff_size(w[Z_LSB +: DIM_W]);
    // packed as {outer, middle, inner}
    case (w[P_LSB +: PERM_W])
      3'd1:    s.order = {AX_Y, AX_Z, AX_X};
      3'd2:    s.order = {AX_Z, AX_X, AX_Y};
      3'd3:    s.order = {AX_X, AX_Z, AX_Y};
      3'd4:    s.order = {AX_Y, AX_X, AX_Z};
      3'd5:    s.order = {AX_X, AX_Y, AX_Z};
      default: s.order = {AX_Z, AX_Y, AX_X};
    endcase
    return s;
  endfunction
endpackage

// File: rtl/remap_axis_walk.sv
module remap_axis_walk
  import remap_pkg::*;
(
  input  logic [NAX-1:0][DIM_W-1:0] coord_i,
  input  logic [NAX-1:0][DIM_W-1:0] lim_i,
  input  axis_t [NAX-1:0]           order_i,
  output logic [NAX-1:0][DIM_W-1:0] coord_o
);
  // odometer step: innermost axis first, carry outward
  always_comb begin
    logic carry;
    axis_t a;
    coord_o = coord_i;
    carry   = 1'b1;
    for (int k = 0; k < NAX; k++) begin
      a = order_i[k];
      if (carry) begin
        if ({1'b0, coord_i[a]} + (DIM_W+1)'(1) == {1'b0, lim_i[a]}) begin
          coord_o[a] = '0;
        end else begin
          coord_o[a] = coord_i[a] + DIM_W'(1);
          carry      = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/remap_linearize.sv
module remap_linearize
  import remap_pkg::*;
(
  input  logic [NAX-1:0][DIM_W-1:0] coord_i,
  input  logic [NAX-1:0][DIM_W-1:0] lim_i,
  input  logic [NAX-1:0]            inv_i,
  output logic [IDX_W-1:0]          idx_o
);
  logic [NAX-1:0][DIM_W-1:0] pos;

  for (genvar g = 0; g < NAX; g++) begin : g_ax
    assign pos[g] = inv_i[g] ? (lim_i[g] - DIM_W'(1) - coord_i[g]) : coord_i[g];
  end

  assign idx_o = IDX_W'(pos[0])
               + IDX_W'(pos[1]) * IDX_W'(lim_i[0])
               + IDX_W'(pos[2]) * IDX_W'(lim_i[0]) * IDX_W'(lim_i[1]);
endmodule

// File: rtl/remap_mod_reduce.sv
module remap_mod_reduce #(
  parameter int unsigned IW = 18,
  parameter int unsigned MW = 6
) (
  input  logic [IW-1:0] val_i,
  input  logic [MW-1:0] mod_i,
  output logic [IW-1:0] val_o
);
  localparam int unsigned EW = IW + MW;

  logic [IW:0][IW-1:0] rem;
  assign rem[0] = val_i;

  // restoring reduction: subtract mod<<sh when it fits, sh from IW-1 down to 0
  for (genvar g = 0; g < IW; g++) begin : g_stage
    localparam int unsigned SH = IW - 1 - g;
    logic [EW-1:0] dvs;
    logic          fits;
    assign dvs  = EW'(mod_i) << SH;
    assign fits = (EW'(rem[g]) >= dvs);
    assign rem[g+1] = fits ? (rem[g] - dvs[IW-1:0]) : rem[g];
  end

  assign val_o = (mod_i == '0) ? val_i : rem[IW];
endmodule

// File: rtl/idx_remap_gen.sv
module idx_remap_gen
  import remap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [IDX_W-1:0] vl_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  shape_t shp_cfg, shp_q, shp;
  logic [NAX-1:0][DIM_W-1:0] coord_q, coord_step, coord_nxt;
  logic [IDX_W-1:0] lin_q, lin_nxt, raw_idx, red_idx, idx_nxt, total;
  logic [IDX_W-1:0] rem_q;
  logic             active_q, last_q, fire;

  assign shp_cfg = decode_shape(cfg_i);
  assign shp     = start_i ? shp_cfg : shp_q;
  assign fire    = active_q & ready_i;

  remap_axis_walk u_walk (
    .coord_i (coord_q),
    .lim_i   (shp_q.lim),
    .order_i (shp_q.order),
    .coord_o (coord_step)
  );

  assign coord_nxt = start_i ? '0 : coord_step;
  assign lin_nxt   = start_i ? '0 : lin_q + IDX_W'(1);

  remap_linearize u_lin (
    .coord_i (coord_nxt),
    .lim_i   (shp.lim),
    .inv_i   (shp.inv),
    .idx_o   (raw_idx)
  );

  remap_mod_reduce #(.IW(IDX_W), .MW(DIM_W)) u_mod (
    .val_i (raw_idx),
    .mod_i (shp.modv),
    .val_o (red_idx)
  );

  assign idx_nxt = shp.bypass ? lin_nxt : red_idx;

  always_comb begin
    if (shp_cfg.bypass) total = (vl_i == '0) ? IDX_W'(1) : vl_i;
    else total = IDX_W'(shp_cfg.lim[0]) * IDX_W'(shp_cfg.lim[1]) * IDX_W'(shp_cfg.lim[2]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shp_q    <= '0;
      coord_q  <= '0;
      lin_q    <= '0;
      rem_q    <= '0;
      idx_o    <= '0;
      active_q <= 1'b0;
      last_q   <= 1'b0;
    end else if (start_i) begin
      shp_q    <= shp_cfg;
      coord_q  <= coord_nxt;
      lin_q    <= lin_nxt;
      rem_q    <= total;
      idx_o    <= idx_nxt;
      active_q <= 1'b1;
      last_q   <= (total == IDX_W'(1));
    end else if (fire) begin
      if (last_q) begin
        active_q <= 1'b0;
        last_q   <= 1'b0;
      end else begin
        coord_q <= coord_nxt;
        lin_q   <= lin_nxt;
        rem_q   <= rem_q - IDX_W'(1);
        idx_o   <= idx_nxt;
        last_q  <= (rem_q == IDX_W'(2));
      end
    end
  end

  assign valid_o = active_q;
  assign last_o  = last_q;
endmodule

// File: rtl/remap_chk.sv
module remap_chk
  import remap_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic             ready_i,
  input logic             valid_o,
  input logic [IDX_W-1:0] idx_o,
  input logic             last_o
);
  logic [DIM_W-1:0] mod_q;
  logic             flat_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q  <= '0;
      flat_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      mod_q  <= cfg_i[M_LSB +: DIM_W];
      flat_q <= (cfg_i == '0);
      cnt_q  <= '0;
    end else if (valid_o && ready_i) begin
      cnt_q <= cnt_q + IDX_W'(1);
    end
  end

  AST_START_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o); // R2
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !start_i) |=> (valid_o && $stable(idx_o) && $stable(last_o))); // R2
  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && last_o && !start_i) |=> !valid_o); // R8
  AST_MOD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mod_q != '0) |-> (idx_o < IDX_W'(mod_q))); // R7
  AST_FLAT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flat_q) |-> (idx_o == cnt_q)); // R9
endmodule

bind idx_remap_gen remap_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .cfg_i   (cfg_i),
  .ready_i (ready_i),
  .valid_o (valid_o),
  .idx_o   (idx_o),
  .last_o  (last_o)
);

// File: tb/sim_idx_remap_gen.sv
module sim_idx_remap_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] cfg_i = '0;
  logic [17:0] vl_i = '0;
  logic        ready_i = 1'b0;
  logic        valid_o, last_o;
  logic [17:0] idx_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  idx_remap_gen u0 (.*);

  function automatic logic [31:0] mk(int x, int y, int z, int p, int iv, int m);
    return {2'b00, 6'(m), 3'(iv), 3'(p), 6'(z), 6'(y), 6'(x)};
  endfunction

  function automatic int lim_of(logic [5:0] f);
    return (f == 0) ? 1 : int'(f);
  endfunction

  function automatic int exp_total(logic [31:0] c, int vl);
    if (c == 0) return (vl == 0) ? 1 : vl;
    return lim_of(c[5:0]) * lim_of(c[11:6]) * lim_of(c[17:12]);
  endfunction

  // coordinates of element n by mixed-radix division
  function automatic int exp_idx(logic [31:0] c, int n);
    int l[3], ord[3], crd[3], r, idx, m;
    if (c == 0) return n;
    l[0] = lim_of(c[5:0]); l[1] = lim_of(c[11:6]); l[2] = lim_of(c[17:12]);
    case (c[20:18])
      3'd1: ord = '{0, 2, 1};
      3'd2: ord = '{1, 0, 2};
      3'd3: ord = '{1, 2, 0};
      3'd4: ord = '{2, 0, 1};
      3'd5: ord = '{2, 1, 0};
      default: ord = '{0, 1, 2};
    endcase
    r = n;
    for (int k = 0; k < 3; k++) begin
      crd[ord[k]] = r % l[ord[k]];
      r = r / l[ord[k]];
    end
    for (int a = 0; a < 3; a++)
      if (c[21 + a]) crd[a] = l[a] - 1 - crd[a];
    idx = crd[0] + crd[1] * l[0] + crd[2] * l[0] * l[1];
    m = int'(c[29:24]);
    if (m != 0) idx = idx % m;
    return idx;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  localparam int N = 15;
  localparam logic [31:0] CFG_TAB [N] = '{
    mk(4, 4, 0, 0, 0, 0),   // R3 plain 2D
    mk(4, 4, 0, 2, 0, 0),   // R5 transpose
    mk(3, 2, 2, 5, 0, 0),   // R5
    mk(2, 3, 2, 1, 0, 0),   // R5
    mk(2, 3, 2, 3, 0, 0),   // R5
    mk(2, 3, 2, 4, 0, 0),   // R5
    mk(3, 2, 2, 7, 0, 0),   // R5 fallback code
    mk(3, 2, 2, 0, 5, 0),   // R6 x and z reversed
    mk(4, 4, 0, 0, 0, 5),   // R7
    mk(5, 0, 0, 0, 0, 0),   // R4
    32'h0,                  // R9
    mk(3, 3, 2, 3, 7, 7),   // R6 all reversed with wrap
    mk(63, 2, 0, 0, 0, 63), // R7 wide x
    32'h0,                  // R9 zero length
    mk(0, 0, 3, 6, 2, 0)    // R4 only z used
  };
  localparam logic [17:0] VL_TAB [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7, 0, 0, 0, 0};
  localparam logic [15:0] TAG_TAB [N] = '{"R3", "R5", "R5", "R5", "R5", "R5", "R5",
                                          "R6", "R7", "R4", "R9", "R6", "R7", "R9", "R4"};

  task automatic kick(logic [31:0] c, logic [17:0] vl, logic rdy);
    @(negedge clk_i);
    start_i = 1'b1; cfg_i = c; vl_i = vl; ready_i = rdy;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic run_vec(logic [31:0] c, logic [17:0] vl, string tag);
    int tot;
    tot = exp_total(c, int'(vl));
    kick(c, vl, 1'b1);
    for (int n = 0; n < tot; n++) begin
      check("R2", "valid", int'(valid_o), 1);
      check(tag, $sformatf("idx[%0d] cfg=%h", n, c), int'(idx_o), exp_idx(c, n));
      check("R8", "last", int'(last_o), (n == tot - 1) ? 1 : 0);
      @(negedge clk_i);
    end
    check("R8", "idle after last", int'(valid_o), 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "valid after reset", int'(valid_o), 0);
    check("R1", "last after reset", int'(last_o), 0);
    check("R1", "idx after reset", int'(idx_o), 0);

    for (int v = 0; v < N; v++)
      run_vec(CFG_TAB[v], VL_TAB[v], string'(TAG_TAB[v]));

    // R2 stall: ready low holds the first index
    kick(mk(4, 4, 0, 2, 0, 0), 0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      check("R2", "stall valid", int'(valid_o), 1);
      check("R2", "stall idx", int'(idx_o), 0);
      @(negedge clk_i);
    end
    ready_i = 1'b1;
    @(negedge clk_i);
    check("R2", "idx after stall", int'(idx_o), 4);
    @(negedge clk_i);
    check("R2", "idx next", int'(idx_o), 8);

    // R10 restart mid-sequence, ready low at restart
    ready_i = 1'b0;
    kick(mk(3, 2, 0, 0, 1, 0), 0, 1'b0);
    check("R10", "restart valid", int'(valid_o), 1);
    check("R10", "restart idx", int'(idx_o), 2);
    ready_i = 1'b1;
    @(negedge clk_i);
    check("R10", "restart idx 1", int'(idx_o), 1);
    for (int k = 0; k < 5; k++) @(negedge clk_i);
    check("R10", "restart ends", int'(valid_o), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule